// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block picks which of eight interrupt lines an interrupt controller should present next, and which in-service line a non-specific end-of-interrupt should retire. Priority is circular: a 3-bit pointer names the lowest-priority line, and the line just after it (modulo 8) is the highest. Out of reset the pointer is 7, so line 0 is the highest.

The block takes the captured request bits and the mask bits from neighbouring logic and holds the in-service bits and the priority pointer itself. An acknowledge pulse marks the current winner as in service. A command port carries three operations: non-specific end-of-interrupt, specific end-of-interrupt and set-priority. Two mode inputs change how in-service bits affect the choice. In special mask mode they are ignored. In special fully nested mode the cascade line is treated as if it were not in service. Both resolver outputs are combinational, taken from the registered state and the current inputs.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the in-service vector is 0 and the lowest-priority pointer is 7.
- R2: Lines are scanned in order starting at (pointer + 1) mod 8, ascending and wrapping through all 8 lines. The first eligible line found is reported on `req_pin_o`.
- R3: A line is eligible only when its request bit is 1 and its mask bit is 0. When no line qualifies, `req_valid_o` is 0.
- R4: Outside special mask mode, the scan stops at the first in-service line it reaches. A request on that line, or on any line after it in scan order, is not reported.
- R5: With `smm_i`=1, in-service bits do not block the scan, so any unmasked request can win.
- R6: With `sfnm_i`=1, in-service bit 2 (the cascade line) does not block the scan.
- R7: When `ack_i`=1 and `req_valid_o`=1, the in-service bit of `req_pin_o` is set at the clock edge.
- R8: `eoi_pin_o` is the first in-service line in scan order, and `eoi_valid_o` is 0 when there is none. With `smm_i`=1, in-service lines whose mask bit is 1 are skipped. A command with `cmd_op_i`=1 (non-specific end-of-interrupt) clears that bit.
- R9: A command with `cmd_op_i`=2 (specific end-of-interrupt) clears the in-service bit numbered `cmd_arg_i`.
- R10: When `rotate_i`=1, an end-of-interrupt also loads the number of the cleared line into the pointer. When `rotate_i`=0, the pointer is unchanged.
- R11: A command with `cmd_op_i`=3 (set-priority) loads `cmd_arg_i` into the pointer only when `rotate_i`=1. When `rotate_i`=0, the pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| request_i | input | 8 | Captured request bits |
| mask_i | input | 8 | Mask bits, 1 = masked |
| smm_i | input | 1 | Special mask mode |
| sfnm_i | input | 1 | Special fully nested mode |
| rotate_i | input | 1 | Rotation enable |
| ack_i | input | 1 | Mark the current winner as in service |
| cmd_op_i | input | 2 | 0 none, 1 non-specific EOI, 2 specific EOI, 3 set priority |
| cmd_arg_i | input | 3 | Line number for specific EOI or set priority |
| req_valid_o | output | 1 | An eligible request exists |
| req_pin_o | output | 3 | Winning request line |
| eoi_valid_o | output | 1 | A line can be retired by a non-specific EOI |
| eoi_pin_o | output | 3 | Line that a non-specific EOI would retire |
| isr_o | output | 8 | In-service vector |
| lowprio_o | output | 3 | Lowest-priority pointer |

## Verification
The bench moves the pointer to several positions and checks the wrap-around. A scan that started at the pointer itself, or that did not wrap, would report the wrong line. It checks that an in-service line blocks a request on the same line. A design that tested the request before the blocker would let a re-entrant request through. Both special modes are checked, and so is a non-specific end-of-interrupt in special mask mode, which must skip a masked in-service line rather than clear it. Rotation and set-priority are each issued with rotation off, where a design that ignored the enable would move the pointer.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_EOI_NS  = 2'd1,
    CMD_EOI_SP  = 2'd2,
    CMD_SET_PRI = 2'd3
  } cmd_e;
endpackage

// File: rtl/irq_prio_scan.sv
// Circular first-hit search starting one past the lowest-priority pointer.
// A set blocker bit ends the search before its own candidate is looked at.
module irq_prio_scan #(
  parameter int N  = 8,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [N-1:0]  block,
  input  logic [PW-1:0] ptr,
  output logic          hit,
  output logic [PW-1:0] pin
);
  logic [PW:0] idx;
  logic        stop;

  always_comb begin
    hit  = 1'b0;
    pin  = '0;
    stop = 1'b0;
    idx  = '0;
    for (int i = 0; i < N; i++) begin
      idx = {1'b0, ptr} + (PW+1)'(i + 1);
      if (idx >= (PW+1)'(N)) idx = idx - (PW+1)'(N);
      if (!hit && !stop) begin
        if (block[idx[PW-1:0]]) begin
          stop = 1'b1;
        end else if (cand[idx[PW-1:0]]) begin
          hit = 1'b1;
          pin = idx[PW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_state.sv
// In-service vector and lowest-priority pointer registers.
module irq_prio_state #(
  parameter int N  = 8,
  parameter int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  set_vec,
  input  logic [N-1:0]  clr_vec,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_val,
  output logic [N-1:0]  isr_q,
  output logic [PW-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      ptr_q <= PW'(N - 1);
    end else begin
      isr_q <= (isr_q | set_vec) & ~clr_vec;
      if (ptr_load) ptr_q <= ptr_val;
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N       = 8,
  parameter int CASCADE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         request_i,
  input  logic [N-1:0]         mask_i,
  input  logic                 smm_i,
  input  logic                 sfnm_i,
  input  logic                 rotate_i,
  input  logic                 ack_i,
  input  logic [1:0]           cmd_op_i,
  input  logic [$clog2(N)-1:0] cmd_arg_i,
  output logic                 req_valid_o,
  output logic [$clog2(N)-1:0] req_pin_o,
  output logic                 eoi_valid_o,
  output logic [$clog2(N)-1:0] eoi_pin_o,
  output logic [N-1:0]         isr_o,
  output logic [$clog2(N)-1:0] lowprio_o
);
  import irq_prio_pkg::*;
  localparam int PW = $clog2(N);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE;

  cmd_e          op;
  logic [N-1:0]  isr_q;
  logic [PW-1:0] ptr_q;
  logic [N-1:0]  req_cand, req_block, eoi_cand;
  logic [N-1:0]  set_vec, clr_vec;
  logic          ptr_load;
  logic [PW-1:0] ptr_val;

  assign op = cmd_e'(cmd_op_i);

  // Request side: masked lines never qualify; in-service lines block
  // unless special mask mode, and the cascade line is exempt in SFNM.
  assign req_cand  = request_i & ~mask_i;
  assign req_block = smm_i ? '0 : (isr_q & ~(sfnm_i ? CASC_BIT : '0));

  // Retire side: in special mask mode masked in-service lines are skipped.
  assign eoi_cand  = isr_q & ~(smm_i ? mask_i : '0);

  irq_prio_scan #(.N(N), .PW(PW)) u_req_scan (
    .cand (req_cand),
    .block(req_block),
    .ptr  (ptr_q),
    .hit  (req_valid_o),
    .pin  (req_pin_o)
  );

  irq_prio_scan #(.N(N), .PW(PW)) u_eoi_scan (
    .cand (eoi_cand),
    .block('0),
    .ptr  (ptr_q),
    .hit  (eoi_valid_o),
    .pin  (eoi_pin_o)
  );

  always_comb begin
    set_vec  = (ack_i && req_valid_o) ? (N'(1) << req_pin_o) : '0;
    clr_vec  = '0;
    ptr_load = 1'b0;
    ptr_val  = cmd_arg_i;
    unique case (op)
      CMD_EOI_NS: if (eoi_valid_o) begin
        clr_vec  = N'(1) << eoi_pin_o;
        ptr_load = rotate_i;
        ptr_val  = eoi_pin_o;
      end
      CMD_EOI_SP: begin
        clr_vec  = N'(1) << cmd_arg_i;
        ptr_load = rotate_i;
      end
      CMD_SET_PRI: ptr_load = rotate_i;
      default: ;
    endcase
  end

  irq_prio_state #(.N(N), .PW(PW)) u_state (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .ptr_load(ptr_load),
    .ptr_val (ptr_val),
    .isr_q   (isr_q),
    .ptr_q   (ptr_q)
  );

  assign isr_o     = isr_q;
  assign lowprio_o = ptr_q;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0]         request_i,
  input logic [N-1:0]         mask_i,
  input logic                 smm_i,
  input logic                 rotate_i,
  input logic                 ack_i,
  input logic [1:0]           cmd_op_i,
  input logic [$clog2(N)-1:0] cmd_arg_i,
  input logic                 req_valid_o,
  input logic [$clog2(N)-1:0] req_pin_o,
  input logic                 eoi_valid_o,
  input logic [$clog2(N)-1:0] eoi_pin_o,
  input logic [N-1:0]         isr_o,
  input logic [$clog2(N)-1:0] lowprio_o
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isr_o == '0 && lowprio_o == $clog2(N)'(N - 1)));

  p_winner_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (request_i[req_pin_o] && !mask_i[req_pin_o]));

  p_ack_marks_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_valid_o && cmd_op_i == 2'd0) |=> isr_o[$past(req_pin_o)]);

  p_retire_in_service_r8: assert property (@(posedge clk) disable iff (rst)
    eoi_valid_o |-> (isr_o[eoi_pin_o] && !(smm_i && mask_i[eoi_pin_o])));

  p_specific_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_op_i == 2'd2) |=> !isr_o[$past(cmd_arg_i)]);

  p_setpri_held_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_op_i == 2'd3 && !rotate_i) |=> $stable(lowprio_o));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N(N)) u_chk (.*);

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] request_i = '0, mask_i = '0;
  logic       smm_i = 0, sfnm_i = 0, rotate_i = 0, ack_i = 0;
  logic [1:0] cmd_op_i = '0;
  logic [2:0] cmd_arg_i = '0;
  logic       req_valid_o, eoi_valid_o;
  logic [2:0] req_pin_o, eoi_pin_o, lowprio_o;
  logic [7:0] isr_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_prio_resolver uut (.*);

  // {pointer, request, mask, valid, pin}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {3'd7, 8'h00, 8'h00, 1'b0, 3'd0},
    {3'd7, 8'h81, 8'h00, 1'b1, 3'd0},
    {3'd7, 8'h81, 8'h01, 1'b1, 3'd7},
    {3'd3, 8'h19, 8'h00, 1'b1, 3'd4},
    {3'd3, 8'h09, 8'h00, 1'b1, 3'd0},
    {3'd0, 8'h01, 8'h00, 1'b1, 3'd0},
    {3'd5, 8'h42, 8'h00, 1'b1, 3'd6},
    {3'd6, 8'h42, 8'h00, 1'b1, 3'd1},
    {3'd2, 8'hFF, 8'hFF, 1'b0, 3'd0},
    {3'd2, 8'hFF, 8'hF8, 1'b1, 3'd0}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic command(logic [1:0] op, logic [2:0] arg, logic rot);
    @(negedge clk);
    cmd_op_i = op; cmd_arg_i = arg; rotate_i = rot;
    @(negedge clk);
    cmd_op_i = '0; rotate_i = 0;
    #2;
  endtask

  task automatic acknowledge();
    @(negedge clk);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    check("R1 isr", isr_o, 8'h00);
    check("R1 pointer", lowprio_o, 7);

    // R2/R3 table
    for (int k = 0; k < NV; k++) begin
      command(2'd3, VEC[k][22:20], 1'b1);
      request_i = VEC[k][19:12];
      mask_i    = VEC[k][11:4];
      #2;
      check("R2 R3 valid", req_valid_o, VEC[k][3]);
      if (VEC[k][3]) check("R2 R3 pin", req_pin_o, VEC[k][2:0]);
    end
    mask_i = '0;
    command(2'd3, 3'd7, 1'b1);

    // R7 then R4
    request_i = 8'h10;
    acknowledge();
    check("R7 isr set", isr_o, 8'h10);
    request_i = 8'h30; #2;
    check("R4 same line blocked", req_valid_o, 0);
    request_i = 8'h09; #2;
    check("R4 higher passes valid", req_valid_o, 1);
    check("R4 higher passes pin", req_pin_o, 0);
    request_i = 8'h20; #2;
    check("R4 lower blocked", req_valid_o, 0);

    // R5
    smm_i = 1; #2;
    check("R5 smm valid", req_valid_o, 1);
    check("R5 smm pin", req_pin_o, 5);
    smm_i = 0;

    // R9
    command(2'd2, 3'd4, 1'b0);
    check("R9 specific clear", isr_o, 8'h00);
    check("R10 no rotate", lowprio_o, 7);

    // R6
    request_i = 8'h04;
    acknowledge();
    request_i = 8'h08; #2;
    check("R6 cascade blocks w/o sfnm", req_valid_o, 0);
    sfnm_i = 1; #2;
    check("R6 sfnm valid", req_valid_o, 1);
    check("R6 sfnm pin", req_pin_o, 3);
    sfnm_i = 0;

    // R8 non-specific, no rotation
    request_i = 8'h01;
    acknowledge();
    check("R7 isr two bits", isr_o, 8'h05);
    check("R8 eoi pin", eoi_pin_o, 0);
    command(2'd1, 3'd0, 1'b0);
    check("R8 ns clear", isr_o, 8'h04);
    check("R10 pointer held", lowprio_o, 7);

    // R8 special mask skip, R10 rotation
    request_i = 8'h01;
    acknowledge();
    mask_i = 8'h01; smm_i = 1; request_i = '0; #2;
    check("R8 smm skip pin", eoi_pin_o, 2);
    command(2'd1, 3'd0, 1'b1);
    check("R8 smm ns clear", isr_o, 8'h01);
    check("R10 rotate load", lowprio_o, 2);
    mask_i = '0; smm_i = 0;
    command(2'd2, 3'd0, 1'b1);
    check("R9 specific clear 0", isr_o, 8'h00);
    check("R10 specific rotate", lowprio_o, 0);
    #2;
    check("R8 none valid", eoi_valid_o, 0);

    // R11
    command(2'd3, 3'd5, 1'b0);
    check("R11 ignored w/o rotate", lowprio_o, 0);
    command(2'd3, 3'd5, 1'b1);
    check("R11 loaded", lowprio_o, 5);
    request_i = 8'h41; #2;
    check("R2 rotated pin", req_pin_o, 6);

    finish_run();
  end
endmodule